// File: doc/BRIEF.md
# Four-Lane Odd Parity Checker and Generator

This block guards the parallel character interfaces of a four-lane serial link with odd parity. On the transmit side each lane presents a 10-bit character together with a parity bit; the block checks that the eleven bits hold an odd number of ones and raises a registered per-lane error flag when they do not. On the receive side each lane presents a 10-bit character and a comma-detect status bit. The block registers them and adds an odd parity bit, so that character, status and parity leave the block in the same cycle.

A single static 2-bit mode input governs every lane. Encoding `2'b00` turns parity off. In this mode transmit checking is suppressed and the receive parity outputs are released through their output-enable. Encoding `2'b01` checks transmit parity and generates receive parity over the data bits only. Encoding `2'b10` checks transmit parity the same way and extends receive parity coverage to the comma-detect bit. Encoding `2'b11` is unused and behaves exactly like `2'b00`. The physical tristate buffer sits outside the block and is driven from `rx_par_oe`.

Top module: `par_guard`

## Requirements
- R1: While `rst_n` is low, `tx_err`, `rx_par_out`, `rx_par_oe`, `rx_char_out` and `rx_comma_out` are all zero.
- R2: `mode_sel` is decoded as 00 = off, 01 = data-only, 10 = data-plus-status and 11 = off. One value applies to all lanes at once.
- R3: In modes 01 and 10, bit i of `tx_err` is 1 in the cycle after a clock edge exactly when lane i's 10 character bits (`tx_char[10i+9:10i]`) plus `tx_par[i]` contain an even number of ones. Otherwise the bit is 0.
- R4: In modes 00 and 11, every `tx_err` bit is 0 in the cycle after the edge, whatever the transmit characters and parity bits are.
- R5: In mode 01, `rx_par_out[i]` after an edge is chosen so that the registered 10-bit character of lane i plus that parity bit holds an odd number of ones. The comma bit has no effect.
- R6: In mode 10, `rx_par_out[i]` is chosen so that the registered character, the registered comma bit and the parity bit of lane i together hold an odd number of ones.
- R7: In modes 00 and 11, `rx_par_oe` is 0 on every lane and `rx_par_out` is driven 0. In modes 01 and 10, `rx_par_oe` is 1 on every lane.
- R8: `rx_char_out` and `rx_comma_out` are the receive inputs delayed by exactly one clock in every mode, and the parity and enable bits appear in that same cycle.
- R9: Lanes are independent. An error or parity value on one lane depends only on that lane's inputs and the shared mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock for both directions |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Shared parity mode (00 off, 01 data, 10 data+status, 11 off) |
| tx_char | input | 40 | Transmit characters, lane i at bits 10i+9..10i |
| tx_par | input | 4 | Transmit parity bit per lane |
| tx_err | output | 4 | Registered transmit parity error per lane |
| rx_char_in | input | 40 | Receive characters, lane i at bits 10i+9..10i |
| rx_comma_in | input | 4 | Comma-detect status per lane |
| rx_char_out | output | 40 | Registered receive characters |
| rx_comma_out | output | 4 | Registered comma-detect status |
| rx_par_out | output | 4 | Generated odd parity per lane |
| rx_par_oe | output | 4 | Output enable for the receive parity pins |

## Verification
The hardest case to reach from the ports is one that separates the two active modes on the receive side. A lane must carry its comma bit set while its data parity alone would look correct, and the mode must then switch between 01 and 10 from one cycle to the next with the data held still. The unused encoding 11 also has to appear while the transmit lanes carry bad parity. Directed vectors set up both cases: all-zero and all-one characters, a walking single-bit pattern, and back-to-back mode switches on fixed data. Random stimulus from a fixed seed then mixes all four mode codes with arbitrary lane data and parity, so that error and clean lanes appear side by side in the same cycle.

// File: rtl/par_guard_pkg.sv
// Package par_guard_pkg
// Holds the shared mode encoding of the four-lane parity guard.
// Assumes the mode input is static or changes only between characters.
package par_guard_pkg;

    typedef enum logic [1:0] {
        PM_OFF       = 2'b00,
        PM_DATA      = 2'b01,
        PM_DATA_STAT = 2'b10,
        PM_SPARE     = 2'b11
    } par_mode_e;

endpackage

// File: rtl/par_mode_dec.sv
// Module par_mode_dec
// Turns the 2-bit shared mode code into per-function enables.
// Assumes the spare code is to behave as the off setting.
module par_mode_dec
    import par_guard_pkg::*;
(
    input  logic [1:0] mode_sel,
    output logic       chk_en,
    output logic       gen_en,
    output logic       stat_en
);

    par_mode_e mode;

    // Decode the mode code into check, generate and status-coverage enables.
    always_comb begin
        mode    = par_mode_e'(mode_sel);
        chk_en  = 1'b0;
        gen_en  = 1'b0;
        stat_en = 1'b0;
        case (mode)
            PM_DATA: begin
                chk_en = 1'b1;
                gen_en = 1'b1;
            end
            PM_DATA_STAT: begin
                chk_en  = 1'b1;
                gen_en  = 1'b1;
                stat_en = 1'b1;
            end
            default: begin
                chk_en  = 1'b0;
                gen_en  = 1'b0;
                stat_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/par_tx_chk.sv
// Module par_tx_chk
// Checks one transmit lane for odd parity over character plus parity bit.
// Assumes the character and parity bit are valid on every clock edge.
module par_tx_chk #(
    parameter int CHAR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              par_in,
    output logic              err_q
);

    localparam int CHK_W = CHAR_W + 1;

    logic [CHK_W-1:0] chk_word;
    logic             even_ones;

    // Form the checked word and flag an even count of ones.
    always_comb begin
        chk_word  = {par_in, char_in};
        even_ones = ~(^chk_word);
    end

    // Register the error flag, held low while checking is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= chk_en & even_ones;
        end
    end

endmodule

// File: rtl/par_rx_gen.sv
// Module par_rx_gen
// Registers one receive lane and adds an odd parity bit, optionally
// covering the comma-detect bit as well.
// Assumes the parity pin's physical tristate is built outside from oe_q.
module par_rx_gen #(
    parameter int CHAR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              stat_en,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              comma_in,
    output logic [CHAR_W-1:0] char_q,
    output logic              comma_q,
    output logic              par_q,
    output logic              oe_q
);

    logic data_odd;
    logic par_next;

    // Compute the parity bit that makes the covered field odd.
    always_comb begin
        data_odd = ^char_in;
        par_next = ~(data_odd ^ (stat_en & comma_in));
    end

    // Register data, status, parity and enable together so they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q  <= '0;
            comma_q <= 1'b0;
            par_q   <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            char_q  <= char_in;
            comma_q <= comma_in;
            par_q   <= gen_en & par_next;
            oe_q    <= gen_en;
        end
    end

endmodule

// File: rtl/par_guard.sv
// Module par_guard
// Four-lane odd parity checker (transmit) and generator (receive) under
// one shared three-setting mode control.
// Assumes all lanes share one character clock and a static mode code.
module par_guard #(
    parameter int NUM_LANES = 4,
    parameter int CHAR_W    = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  mode_sel,
    input  logic [NUM_LANES*CHAR_W-1:0] tx_char,
    input  logic [NUM_LANES-1:0]        tx_par,
    output logic [NUM_LANES-1:0]        tx_err,
    input  logic [NUM_LANES*CHAR_W-1:0] rx_char_in,
    input  logic [NUM_LANES-1:0]        rx_comma_in,
    output logic [NUM_LANES*CHAR_W-1:0] rx_char_out,
    output logic [NUM_LANES-1:0]        rx_comma_out,
    output logic [NUM_LANES-1:0]        rx_par_out,
    output logic [NUM_LANES-1:0]        rx_par_oe
);

    logic chk_en;
    logic gen_en;
    logic stat_en;

    par_mode_dec u_dec (
        .mode_sel (mode_sel),
        .chk_en   (chk_en),
        .gen_en   (gen_en),
        .stat_en  (stat_en)
    );

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        par_tx_chk #(.CHAR_W(CHAR_W)) u_tx (
            .clk     (clk),
            .rst_n   (rst_n),
            .chk_en  (chk_en),
            .char_in (tx_char[ln*CHAR_W +: CHAR_W]),
            .par_in  (tx_par[ln]),
            .err_q   (tx_err[ln])
        );

        par_rx_gen #(.CHAR_W(CHAR_W)) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_en   (gen_en),
            .stat_en  (stat_en),
            .char_in  (rx_char_in[ln*CHAR_W +: CHAR_W]),
            .comma_in (rx_comma_in[ln]),
            .char_q   (rx_char_out[ln*CHAR_W +: CHAR_W]),
            .comma_q  (rx_comma_out[ln]),
            .par_q    (rx_par_out[ln]),
            .oe_q     (rx_par_oe[ln])
        );
    end

endmodule

// File: rtl/par_guard_chk.sv
// Module par_guard_chk
// Property checker bound to par_guard; watches ports only.
// Assumes synchronous active-low reset as in the design.
module par_guard_chk #(
    parameter int NUM_LANES = 4,
    parameter int CHAR_W    = 10
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  mode_sel,
    input logic [NUM_LANES*CHAR_W-1:0] tx_char,
    input logic [NUM_LANES-1:0]        tx_par,
    input logic [NUM_LANES-1:0]        tx_err,
    input logic [NUM_LANES*CHAR_W-1:0] rx_char_in,
    input logic [NUM_LANES-1:0]        rx_comma_in,
    input logic [NUM_LANES*CHAR_W-1:0] rx_char_out,
    input logic [NUM_LANES-1:0]        rx_comma_out,
    input logic [NUM_LANES-1:0]        rx_par_out,
    input logic [NUM_LANES-1:0]        rx_par_oe
);

    // Outputs are cleared during reset (R1).
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (tx_err == '0 && rx_par_oe == '0 && rx_par_out == '0));

    // Off and spare codes leave no transmit error (R4, R2).
    p_off_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode_sel) == 2'b00 || $past(mode_sel) == 2'b11))
        |-> (tx_err == '0));

    // Disabled parity pins carry zero (R7).
    p_oe_low_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_par_oe == '0) |-> (rx_par_out == '0));

    // Enable follows the active modes (R7).
    p_oe_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_par_oe == (($past(mode_sel) == 2'b01 || $past(mode_sel) == 2'b10)
                                        ? {NUM_LANES{1'b1}} : {NUM_LANES{1'b0}})));

    // Receive data and status are delayed by one clock (R8).
    p_rx_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_char_out == $past(rx_char_in) && rx_comma_out == $past(rx_comma_in)));

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane_chk
        // Data-only parity makes registered char plus parity odd (R5).
        p_data_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_sel) == 2'b01)
            |-> (^{rx_char_out[ln*CHAR_W +: CHAR_W], rx_par_out[ln]} == 1'b1));

        // Status-covered parity includes the registered comma bit (R6).
        p_stat_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mode_sel) == 2'b10)
            |-> (^{rx_char_out[ln*CHAR_W +: CHAR_W], rx_comma_out[ln], rx_par_out[ln]} == 1'b1));

        // Active-mode error tracks the parity of the prior transmit word (R3).
        p_tx_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(mode_sel) == 2'b01 || $past(mode_sel) == 2'b10))
            |-> (tx_err[ln] == ~(^$past({tx_par[ln], tx_char[ln*CHAR_W +: CHAR_W]}))));
    end

endmodule

bind par_guard par_guard_chk #(.NUM_LANES(NUM_LANES), .CHAR_W(CHAR_W)) u_par_guard_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .tx_char      (tx_char),
    .tx_par       (tx_par),
    .tx_err       (tx_err),
    .rx_char_in   (rx_char_in),
    .rx_comma_in  (rx_comma_in),
    .rx_char_out  (rx_char_out),
    .rx_comma_out (rx_comma_out),
    .rx_par_out   (rx_par_out),
    .rx_par_oe    (rx_par_oe)
);

// File: tb/par_guard_bench.sv
module par_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 4;
    localparam int CW         = 10;
    localparam int N_RANDOM   = 3000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_sel = 2'b00;
    logic [NL*CW-1:0] tx_char = '0;
    logic [NL-1:0]    tx_par = '0;
    logic [NL-1:0]    tx_err;
    logic [NL*CW-1:0] rx_char_in = '0;
    logic [NL-1:0]    rx_comma_in = '0;
    logic [NL*CW-1:0] rx_char_out;
    logic [NL-1:0]    rx_comma_out;
    logic [NL-1:0]    rx_par_out;
    logic [NL-1:0]    rx_par_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    par_guard u_par_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .tx_char      (tx_char),
        .tx_par       (tx_par),
        .tx_err       (tx_err),
        .rx_char_in   (rx_char_in),
        .rx_comma_in  (rx_comma_in),
        .rx_char_out  (rx_char_out),
        .rx_comma_out (rx_comma_out),
        .rx_par_out   (rx_par_out),
        .rx_par_oe    (rx_par_oe)
    );

    // Requirement model: is the mode active (R2)?
    function automatic bit active(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    // Expected transmit error vector (R3, R4).
    function automatic logic [NL-1:0] exp_err(input logic [1:0] m,
                                              input logic [NL*CW-1:0] ch,
                                              input logic [NL-1:0] p);
        logic [NL-1:0] r;
        for (int i = 0; i < NL; i++) begin
            int ones = 0;
            for (int b = 0; b < CW; b++) ones += ch[i*CW+b];
            ones += p[i];
            r[i] = active(m) && (ones % 2 == 0);
        end
        return r;
    endfunction

    // Expected receive parity vector (R5, R6, R7).
    function automatic logic [NL-1:0] exp_par(input logic [1:0] m,
                                              input logic [NL*CW-1:0] ch,
                                              input logic [NL-1:0] cm);
        logic [NL-1:0] r;
        for (int i = 0; i < NL; i++) begin
            int ones = 0;
            for (int b = 0; b < CW; b++) ones += ch[i*CW+b];
            if (m == 2'b10) ones += cm[i];
            r[i] = active(m) ? (ones % 2 == 0) : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one vector at the falling edge, check at the next falling edge.
    task automatic apply(input logic [1:0] m, input logic [NL*CW-1:0] tc,
                         input logic [NL-1:0] tp, input logic [NL*CW-1:0] rc,
                         input logic [NL-1:0] cm);
        mode_sel    = m;
        tx_char     = tc;
        tx_par      = tp;
        rx_char_in  = rc;
        rx_comma_in = cm;
        @(negedge clk);
        check(active(m) ? "R3 tx_err" : "R4 tx_err", 64'(tx_err), 64'(exp_err(m, tc, tp)));
        check((m == 2'b10) ? "R6 rx_par_out" : ((m == 2'b01) ? "R5 rx_par_out" : "R7 rx_par_out"),
              64'(rx_par_out), 64'(exp_par(m, rc, cm)));
        check("R7 rx_par_oe", 64'(rx_par_oe), active(m) ? 64'({NL{1'b1}}) : 64'd0);
        check("R8 rx_char_out", 64'(rx_char_out), 64'(rc));
        check("R8 rx_comma_out", 64'(rx_comma_out), 64'(cm));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: reset state with busy inputs and an active mode.
        mode_sel    = 2'b01;
        tx_char     = '0;
        rx_char_in  = {NL*CW{1'b1}};
        rx_comma_in = '1;
        repeat (3) @(negedge clk);
        check("R1 tx_err", 64'(tx_err), 64'd0);
        check("R1 rx_par_out", 64'(rx_par_out), 64'd0);
        check("R1 rx_par_oe", 64'(rx_par_oe), 64'd0);
        check("R1 rx_char_out", 64'(rx_char_out), 64'd0);
        check("R1 rx_comma_out", 64'(rx_comma_out), 64'd0);
        rst_n = 1'b1;

        // R3: all-zero words with zero parity are errors; all-ones with parity 1 are clean.
        apply(2'b01, '0, '0, '0, '0);
        apply(2'b10, {NL*CW{1'b1}}, '1, {NL*CW{1'b1}}, '1);
        // R9: lanes mixed clean and bad in one cycle.
        apply(2'b01, {10'h001, 10'h000, 10'h3ff, 10'h3fe}, 4'b0101, {10'h001, 10'h000, 10'h3ff, 10'h003}, 4'b1010);
        // R4 / R2: spare and off codes with bad parity on every lane.
        apply(2'b11, '0, '0, {10'h001, 10'h002, 10'h004, 10'h008}, '1);
        apply(2'b00, '0, '0, {10'h001, 10'h002, 10'h004, 10'h008}, '1);
        // R5 vs R6: same data, comma set, switching between active modes.
        for (int k = 0; k < 4; k++) begin
            apply(2'b01, '0, '1, {NL{10'h155}}, '1);
            apply(2'b10, '0, '1, {NL{10'h155}}, '1);
        end
        // Walking single-bit on transmit and receive characters.
        for (int b = 0; b < NL*CW; b++) begin
            apply(2'(b % 3), (NL*CW)'(1) << b, '0, (NL*CW)'(1) << b, 4'(b));
        end
        // Random mix of all modes and lane contents.
        for (int v = 0; v < N_RANDOM; v++) begin
            apply(2'($urandom), {$urandom, $urandom}, 4'($urandom),
                  {$urandom, $urandom}, 4'($urandom));
        end
        // R1: reset mid-stream clears outputs again.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 tx_err re-reset", 64'(tx_err), 64'd0);
        check("R1 rx_par_oe re-reset", 64'(rx_par_oe), 64'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule